// File: doc/BRIEF.md
# Timekeeping Read Snapshot Latch

This block stands between the free-running clock/calendar counters and the serial read path of a real-time clock. When the serial interface reports that a read command for the timekeeping space has just been acknowledged, the block copies all eight timekeeping registers into a holding bank in one step. Every byte the serial side then reads comes from that frozen copy, whether it reads one register or a burst of them. The live counters keep counting the whole time.

A capture must never land on the edge where the seconds counter updates, because the counters may be part-way through a ripple at that point. When a capture request meets the seconds-update strobe, the capture is deferred to the next cycle in which no strobe is present. It then picks up the values after the update. Requests for the RAM space, write commands and commands with the enable bit clear leave the bank untouched.

The bank is indexed in this order: 0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 day of week, 6 year, 7 century. The serial side reads one register per cycle through a registered read port.

Top module: `tk_snapshot_latch`

## Requirements
- R1: While `rst` is high, and at the first sample after reset, `snap_flat` and `rd_data` are all zeros.
- R2: A request (`cap_req`=1) carries a qualifying command when `cap_cmd` bit 7 = 1, bit 6 = 0 and bit 0 = 1. If such a request arrives in a cycle with `sec_tick`=0, `snap_flat` equals the `live_flat` value of that cycle from the next cycle on.
- R3: If a qualifying request arrives in a cycle with `sec_tick`=1, the bank is not written at that edge. It is written at the following edge with the `live_flat` value of the following cycle, provided that cycle has `sec_tick`=0.
- R4: A deferred capture stays pending through every further cycle with `sec_tick`=1. It is taken at the first edge whose cycle has `sec_tick`=0.
- R5: A request whose command has bit 6 = 1, bit 0 = 0 or bit 7 = 0 leaves `snap_flat` unchanged.
- R6: With no qualifying request and no pending capture, `snap_flat` holds its value while `live_flat` changes.
- R7: `rd_data` in a cycle equals the bank entry selected by `rd_addr` in the previous cycle, using the index order given above. Register k occupies bits [8k+7:8k] of both flat buses.
- R8: Command bits 5 to 1 have no effect: every qualifying command captures all eight registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| live_flat | input | 64 | Live counter values, register k in bits [8k+7:8k] |
| sec_tick | input | 1 | Seconds-update strobe; the counters change at this edge |
| cap_req | input | 1 | Capture request, one cycle, at the acknowledge of a command |
| cap_cmd | input | 8 | Address/command byte that goes with the request |
| rd_addr | input | 3 | Register index for the read port |
| rd_data | output | 8 | Registered read data |
| snap_flat | output | 64 | Frozen bank, register k in bits [8k+7:8k] |

## Verification
The assertions check on every cycle that the bank never changes at an edge whose cycle carries the seconds strobe, and that a non-qualifying request with nothing pending leaves the bank alone. They also check that a capture copies exactly the live values and that the read port returns the previously addressed entry. A deferral becoming pending only after a strobe is checked on every cycle as well. The bench's scenarios are needed to show the whole sequence: a strobe-colliding request landing one cycle later with post-update values, a chain of back-to-back strobes, and snapshot contents staying coherent across long random stretches of bursts and live counting.

// File: rtl/tk_snap_pkg.sv
package tk_snap_pkg;
  localparam int REG_W    = 8;
  localparam int NUM_REGS = 8;
  localparam int CMD_W    = 8;
  localparam int CMD_EN_BIT   = 7;
  localparam int CMD_RAM_BIT  = 6;
  localparam int CMD_READ_BIT = 0;
endpackage

// File: rtl/tk_cmd_qualify.sv
module tk_cmd_qualify
  import tk_snap_pkg::*;
#(
  parameter int W = CMD_W
) (
  input  logic         req,
  input  logic [W-1:0] cmd,
  output logic         qual_req
);
  logic en_ok, space_ok, dir_ok;
  always_comb begin
    en_ok    = cmd[CMD_EN_BIT];
    space_ok = !cmd[CMD_RAM_BIT];
    dir_ok   = cmd[CMD_READ_BIT];
    qual_req = req && en_ok && space_ok && dir_ok;
  end
endmodule

// File: rtl/tk_capture_ctrl.sv
module tk_capture_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic qual_req,
  input  logic sec_tick,
  output logic cap_en,
  output logic pending
);
  logic want;
  always_comb begin
    want   = qual_req || pending;
    cap_en = want && !sec_tick;
  end

  always_ff @(posedge clk) begin
    if (rst) pending <= 1'b0;
    else     pending <= want && sec_tick;
  end

  AST_PEND_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
    $rose(pending) |-> $past(sec_tick)); // R4
endmodule

// File: rtl/tk_snap_bank.sv
module tk_snap_bank #(
  parameter int NREG = 8,
  parameter int RW   = 8,
  parameter int AW   = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cap_en,
  input  logic [NREG*RW-1:0] live_flat,
  input  logic [AW-1:0]      rd_addr,
  output logic [RW-1:0]      rd_data,
  output logic [NREG*RW-1:0] snap_flat
);
  logic [RW-1:0] bank [NREG];

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)         bank[k] <= '0;
      else if (cap_en) bank[k] <= live_flat[k*RW +: RW];
    end
    assign snap_flat[k*RW +: RW] = bank[k];
  end

  logic [RW-1:0] rd_sel;
  always_comb begin
    rd_sel = '0;
    for (int i = 0; i < NREG; i++)
      if (int'(rd_addr) == i) rd_sel = bank[i];
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_sel;
  end

  AST_CAPTURE_COPY: assert property (@(posedge clk) disable iff (rst)
    cap_en |=> snap_flat == $past(live_flat)); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !cap_en |=> $stable(snap_flat)); // R6
  AST_READ_PORT: assert property (@(posedge clk) disable iff (rst)
    !cap_en |=> rd_data == snap_flat[$past(rd_addr)*RW +: RW]); // R7
endmodule

// File: rtl/tk_snapshot_latch.sv
module tk_snapshot_latch
  import tk_snap_pkg::*;
#(
  parameter int NREG = NUM_REGS,
  parameter int RW   = REG_W,
  parameter int CW   = CMD_W,
  parameter int AW   = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NREG*RW-1:0] live_flat,
  input  logic               sec_tick,
  input  logic               cap_req,
  input  logic [CW-1:0]      cap_cmd,
  input  logic [AW-1:0]      rd_addr,
  output logic [RW-1:0]      rd_data,
  output logic [NREG*RW-1:0] snap_flat
);
  logic qual_req, cap_en, pending;

  tk_cmd_qualify #(.W(CW)) u_qual (
    .req(cap_req), .cmd(cap_cmd), .qual_req(qual_req)
  );

  tk_capture_ctrl u_ctrl (
    .clk(clk), .rst(rst), .qual_req(qual_req), .sec_tick(sec_tick),
    .cap_en(cap_en), .pending(pending)
  );

  tk_snap_bank #(.NREG(NREG), .RW(RW), .AW(AW)) u_bank (
    .clk(clk), .rst(rst), .cap_en(cap_en), .live_flat(live_flat),
    .rd_addr(rd_addr), .rd_data(rd_data), .snap_flat(snap_flat)
  );

  AST_NO_CAP_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    $past(sec_tick) |-> $stable(snap_flat)); // R3
  AST_IGNORE_BAD_CMD: assert property (@(posedge clk) disable iff (rst)
    (cap_req && !(cap_cmd[CMD_EN_BIT] && !cap_cmd[CMD_RAM_BIT] && cap_cmd[CMD_READ_BIT]) && !pending)
      |=> $stable(snap_flat)); // R5
endmodule

// File: tb/tk_snapshot_latch_test.sv
`timescale 1ns/1ps
module tk_snapshot_latch_test;
  localparam int NREG = 8;
  localparam int RW = 8;

  logic clk = 0;
  logic rst = 1;
  logic [NREG*RW-1:0] live_flat = '0;
  logic sec_tick = 0, cap_req = 0;
  logic [7:0] cap_cmd = '0;
  logic [2:0] rd_addr = '0;
  logic [RW-1:0] rd_data;
  logic [NREG*RW-1:0] snap_flat;

  int total = 0, bad = 0;
  logic [NREG*RW-1:0] msnap = '0;
  logic [RW-1:0] mrd = '0;
  logic mpend = 0;

  always #2.5 clk = ~clk;

  tk_snapshot_latch uut (
    .clk(clk), .rst(rst), .live_flat(live_flat), .sec_tick(sec_tick),
    .cap_req(cap_req), .cap_cmd(cap_cmd), .rd_addr(rd_addr),
    .rd_data(rd_data), .snap_flat(snap_flat)
  );

  function automatic logic qualifies(logic [7:0] c);
    return c[7] && !c[6] && c[0];
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      msnap <= '0; mrd <= '0; mpend <= 0;
    end else begin
      mrd <= msnap[rd_addr*RW +: RW];
      if ((cap_req && qualifies(cap_cmd)) || mpend) begin
        if (sec_tick) mpend <= 1;
        else begin mpend <= 0; msnap <= live_flat; end
      end
    end
  end

  task automatic chk_snap(string tag, logic [NREG*RW-1:0] exp);
    total++;
    if (snap_flat !== exp) begin
      bad++;
      $display("FAIL %s snap act=%h exp=%h", tag, snap_flat, exp);
    end
  endtask

  task automatic chk_rd(string tag, logic [RW-1:0] exp);
    total++;
    if (rd_data !== exp) begin
      bad++;
      $display("FAIL %s rd_data act=%h exp=%h", tag, rd_data, exp);
    end
  endtask

  task automatic step(logic [NREG*RW-1:0] lv, logic rq, logic [7:0] c, logic tk);
    live_flat = lv; cap_req = rq; cap_cmd = c; sec_tick = tk;
    @(negedge clk);
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [NREG*RW-1:0] a, b, c, d, e;
    void'($urandom(32'h1234));
    @(negedge clk); @(negedge clk);
    chk_snap("R1 in reset", '0); chk_rd("R1 in reset", '0);
    rst = 0;
    step(64'h1111, 0, 8'h00, 0);
    chk_snap("R1 after reset", '0); chk_rd("R1 after reset", '0);

    a = 64'h20_99_07_12_31_23_59_58;
    step(a, 1, 8'h81, 0);
    chk_snap("R2 capture", a);
    step(64'hDEAD_BEEF_0000_0001, 0, 8'h81, 0);
    step(64'h0102_0304_0506_0708, 0, 8'h00, 1);
    chk_snap("R6 hold", a);

    step(64'hAAAA, 1, 8'hC1, 0); chk_snap("R5 ram space", a);
    step(64'hBBBB, 1, 8'h80, 0); chk_snap("R5 write", a);
    step(64'hCCCC, 1, 8'h01, 0); chk_snap("R5 enable clear", a);

    b = 64'h5555_0000_1111_2222; c = 64'h5555_0000_1111_2223;
    step(b, 1, 8'h81, 1); chk_snap("R3 no capture on tick", a);
    step(c, 0, 8'h00, 0); chk_snap("R3 deferred post-update", c);

    d = 64'h7777_7777_7777_7777; e = 64'h0F0E_0D0C_0B0A_0908;
    step(64'h1, 1, 8'h81, 1);
    step(d, 0, 8'h00, 1); chk_snap("R4 still pending", c);
    step(e, 0, 8'h00, 0); chk_snap("R4 taken", e);
    step(64'h3, 0, 8'h00, 0); chk_snap("R4 single capture", e);

    a = 64'h0123_4567_89AB_CDEF;
    step(a, 1, 8'hBF, 0); chk_snap("R8 address bits ignored", a);

    for (int k = 0; k < NREG; k++) begin
      rd_addr = 3'(k);
      step(64'h9, 0, 8'h00, 0);
      chk_rd("R7 read sweep", a[k*RW +: RW]);
    end

    for (int n = 0; n < 3000; n++) begin
      logic [7:0] cm;
      cm = 8'($urandom);
      if ($urandom_range(0, 1) == 1) cm = {1'b1, 1'b0, cm[5:1], 1'b1};
      rd_addr = 3'($urandom);
      step({$urandom, $urandom}, ($urandom_range(0, 5) == 0), cm,
           ($urandom_range(0, 3) == 0));
      chk_snap("R2 R3 R5 random", msnap);
      chk_rd("R7 random", mrd);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule